// File: doc/BRIEF.md
# SMBus Block Command Register Engine

This block is the transaction layer of an SMBus target. It sits behind a bit/byte layer that has already turned the pins into events: a START or repeated START pulse, a STOP pulse, a received byte, the master's ACK or NACK after a transmitted byte, and a request for the next byte to transmit. The engine checks the device address and direction bit, decodes a command byte and runs one of four block transactions. It can write the 64-bit seed register, read the seed back, read a 64-bit security code, or read three 8-bit configuration registers in one block.

Reads always begin with a byte-count byte, and 64-bit values go out most-significant byte first. For a seed write, all bytes go into a shadow register. The seed register and the commit pulse to the internal write stage change only when STOP follows a complete write. Writes that are incomplete or malformed are dropped. The security code is captured when its read command is accepted, and its most significant bit is forced to 1.

Top module: `smbus_blk_engine`

## Requirements
- R1: A byte received right after START is acknowledged only when bits [7:1] equal DEV_ADDR (default 7'h2C, so 0x58 for write and 0x59 for read). Any other address is NACKed, and every later byte of that transaction is NACKed and has no effect.
- R2: After address+W, command 0xC0 (seed write), 0xC1 (seed read) and 0xC3 (security read) are ACKed. Any other command byte is NACKed and the transaction is dropped.
- R3: A seed write is address+W, 0xC0, count 0x08, then eight data bytes. Every one of these bytes is ACKed, and the first data byte becomes bits [63:56] of the seed.
- R4: seed_o keeps its old value until STOP arrives after the eighth data byte. In the cycle after that STOP, seed_o takes the new value and commit_o is high for exactly one cycle. commit_o is never high at any other time.
- R5: A write count byte other than 0x08 is NACKed. The write is then dropped, with no commit and no change to seed_o.
- R6: A STOP that arrives before all eight data bytes aborts the write, with no commit and no change to seed_o.
- R7: A seed read is address+W, 0xC1, repeated START, address+R. The engine then returns 0x08 followed by the committed seed, most-significant byte first.
- R8: A security read is the same sequence with 0xC3. sec_code_i is captured when 0xC3 is accepted, and later changes of the input do not affect the returned bytes. Bit 63 of the returned code is always 1.
- R9: An address+R not preceded by a seed or security command returns 0x03, then cfg_i[23:16], cfg_i[15:8] and cfg_i[7:0].
- R10: After the master NACKs a transmitted byte, and after the last data byte of a block, every further transmit request returns 0xFF until the next START.
- R11: ack_valid_o pulses in the cycle after each rx_valid_i. tx_valid_o, with tx_byte_o, pulses in the cycle after each tx_req_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | START or repeated START detected (pulse) |
| stop_i | input | 1 | STOP detected (pulse) |
| rx_valid_i | input | 1 | Byte received from master (pulse) |
| rx_byte_i | input | 8 | Received byte |
| ack_valid_o | output | 1 | Target ACK decision is valid (pulse) |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| tx_req_i | input | 1 | Byte layer requests next byte to send (pulse) |
| tx_valid_o | output | 1 | tx_byte_o is valid (pulse) |
| tx_byte_o | output | 8 | Byte to transmit |
| mack_valid_i | input | 1 | Master acknowledge bit is valid (pulse) |
| mack_i | input | 1 | 1 = master ACK, 0 = master NACK |
| cfg_i | input | CFG_REGS*8 | Configuration registers, first register in the top byte |
| sec_code_i | input | SEED_BYTES*8 | Security code source |
| seed_o | output | SEED_BYTES*8 | Committed seed register |
| commit_o | output | 1 | Seed commit to the internal write stage (pulse) |

## Verification
The hardest case to reach is a security read in which sec_code_i changes between command acceptance and readout. The bench loads one code, issues 0xC3, and then replaces the input with a different value before the repeated START. Every returned byte must still match the first code with bit 63 set. The abort paths need care of the same kind. A STOP after five data bytes, a count of 0x07, and a foreign address are each driven after a good seed has been committed, so that an unchanged seed_o and a silent commit_o show the write was really discarded.

// File: rtl/smbus_blk_pkg.sv
package smbus_blk_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WCNT,
        ST_WDATA,
        ST_WDONE,
        ST_RWAIT,
        ST_READ,
        ST_DROP
    } eng_st_e;

    typedef enum logic [1:0] {
        SRC_CFG,
        SRC_SEED,
        SRC_SEC,
        SRC_NONE
    } rd_src_e;

    localparam logic [7:0] CMD_SEED_WR = 8'hC0;
    localparam logic [7:0] CMD_SEED_RD = 8'hC1;
    localparam logic [7:0] CMD_SEC_RD  = 8'hC3;
    localparam logic [7:0] FILL_BYTE   = 8'hFF;

endpackage

// File: rtl/smbus_seed_store.sv
module smbus_seed_store #(
    parameter int SEED_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    shift_i,
    input  logic [7:0]              byte_i,
    input  logic                    commit_i,
    output logic [SEED_BYTES*8-1:0] seed_o,
    output logic                    commit_o
);
    localparam int SEED_W = SEED_BYTES * 8;

    typedef struct packed {
        logic [SEED_W-1:0] shadow;
        logic [SEED_W-1:0] seed;
        logic              commit;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.commit = 1'b0;
        if (clr_i) begin
            st_d.shadow = '0;
        end
        if (shift_i) begin
            st_d.shadow = {st_q.shadow[SEED_W-9:0], byte_i};
        end
        if (commit_i) begin
            st_d.seed   = st_q.shadow;
            st_d.commit = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seed_o   = st_q.seed;
    assign commit_o = st_q.commit;

    // R4: the visible seed moves only together with a commit pulse
    a_r4_seed_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seed_o) |-> commit_o);

endmodule

// File: rtl/smbus_tx_sel.sv
module smbus_tx_sel
    import smbus_blk_pkg::*;
#(
    parameter int SEED_BYTES = 8,
    parameter int CFG_REGS   = 3,
    parameter int IDX_W      = 4
) (
    input  rd_src_e                 src_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic                    done_i,
    input  logic [SEED_BYTES*8-1:0] seed_i,
    input  logic [SEED_BYTES*8-1:0] sec_i,
    input  logic [CFG_REGS*8-1:0]   cfg_i,
    output logic [7:0]              byte_o
);
    localparam logic [7:0] SEED_CNT = 8'(SEED_BYTES);
    localparam logic [7:0] CFG_CNT  = 8'(CFG_REGS);

    logic [SEED_BYTES*8-1:0] word;

    always_comb begin
        word   = (src_i == SRC_SEED) ? seed_i : sec_i;
        byte_o = FILL_BYTE;
        if (!done_i) begin
            case (src_i)
                SRC_SEED, SRC_SEC: begin
                    if (idx_i == '0) begin
                        byte_o = SEED_CNT;
                    end
                    for (int k = 0; k < SEED_BYTES; k++) begin
                        if (int'(idx_i) == k + 1) begin
                            byte_o = word[(SEED_BYTES-1-k)*8 +: 8];
                        end
                    end
                end
                SRC_CFG: begin
                    if (idx_i == '0) begin
                        byte_o = CFG_CNT;
                    end
                    for (int k = 0; k < CFG_REGS; k++) begin
                        if (int'(idx_i) == k + 1) begin
                            byte_o = cfg_i[(CFG_REGS-1-k)*8 +: 8];
                        end
                    end
                end
                default: byte_o = FILL_BYTE;
            endcase
        end
    end

endmodule

// File: rtl/smbus_blk_engine.sv
module smbus_blk_engine
    import smbus_blk_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h2C,
    parameter int         SEED_BYTES = 8,
    parameter int         CFG_REGS   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    stop_i,
    input  logic                    rx_valid_i,
    input  logic [7:0]              rx_byte_i,
    output logic                    ack_valid_o,
    output logic                    ack_o,
    input  logic                    tx_req_i,
    output logic                    tx_valid_o,
    output logic [7:0]              tx_byte_o,
    input  logic                    mack_valid_i,
    input  logic                    mack_i,
    input  logic [CFG_REGS*8-1:0]   cfg_i,
    input  logic [SEED_BYTES*8-1:0] sec_code_i,
    output logic [SEED_BYTES*8-1:0] seed_o,
    output logic                    commit_o
);
    localparam int         SEED_W   = SEED_BYTES * 8;
    localparam int         CFG_W    = CFG_REGS * 8;
    localparam int         MAXN     = (SEED_BYTES > CFG_REGS) ? SEED_BYTES : CFG_REGS;
    localparam int         IDX_W    = $clog2(MAXN + 2);
    localparam logic [7:0] SEED_CNT = 8'(SEED_BYTES);

    typedef struct packed {
        eng_st_e           st;
        rd_src_e           pend;
        rd_src_e           src;
        logic [IDX_W-1:0]  idx;
        logic              done;
        logic              ack_v;
        logic              ack;
        logic              tx_v;
        logic [7:0]        tx_b;
        logic [SEED_W-1:0] sec;
        logic [CFG_W-1:0]  cfg;
    } eng_t;

    eng_t e_d, e_q;

    logic       seed_clr, seed_shift, seed_commit;
    logic [7:0] sel_byte;

    always_comb begin
        e_d         = e_q;
        e_d.ack_v   = 1'b0;
        e_d.ack     = 1'b0;
        e_d.tx_v    = 1'b0;
        seed_clr    = 1'b0;
        seed_shift  = 1'b0;
        seed_commit = 1'b0;

        if (stop_i) begin
            seed_commit = (e_q.st == ST_WDONE);
            e_d.st      = ST_IDLE;
            e_d.pend    = SRC_NONE;
            e_d.src     = SRC_NONE;
        end else if (start_i) begin
            e_d.st = ST_ADDR;
            if (e_q.st != ST_RWAIT) begin
                e_d.pend = SRC_NONE;
            end
        end else if (rx_valid_i) begin
            e_d.ack_v = 1'b1;
            e_d.st    = ST_DROP;
            case (e_q.st)
                ST_IDLE: e_d.st = ST_IDLE;
                ST_ADDR: begin
                    if (rx_byte_i[7:1] == DEV_ADDR) begin
                        e_d.ack = 1'b1;
                        if (!rx_byte_i[0]) begin
                            e_d.st   = ST_CMD;
                            e_d.pend = SRC_NONE;
                        end else begin
                            e_d.st   = ST_READ;
                            e_d.idx  = '0;
                            e_d.done = 1'b0;
                            e_d.src  = (e_q.pend == SRC_NONE) ? SRC_CFG : e_q.pend;
                            e_d.cfg  = cfg_i;
                        end
                    end
                end
                ST_CMD: begin
                    case (rx_byte_i)
                        CMD_SEED_WR: begin
                            e_d.ack = 1'b1;
                            e_d.st  = ST_WCNT;
                        end
                        CMD_SEED_RD: begin
                            e_d.ack  = 1'b1;
                            e_d.st   = ST_RWAIT;
                            e_d.pend = SRC_SEED;
                        end
                        CMD_SEC_RD: begin
                            e_d.ack  = 1'b1;
                            e_d.st   = ST_RWAIT;
                            e_d.pend = SRC_SEC;
                            e_d.sec  = sec_code_i | {1'b1, {(SEED_W-1){1'b0}}};
                        end
                        default: e_d.st = ST_DROP;
                    endcase
                end
                ST_WCNT: begin
                    if (rx_byte_i == SEED_CNT) begin
                        e_d.ack  = 1'b1;
                        e_d.st   = ST_WDATA;
                        e_d.idx  = '0;
                        seed_clr = 1'b1;
                    end
                end
                ST_WDATA: begin
                    e_d.ack    = 1'b1;
                    seed_shift = 1'b1;
                    e_d.idx    = e_q.idx + 1'b1;
                    e_d.st     = (e_q.idx == IDX_W'(SEED_BYTES - 1)) ? ST_WDONE : ST_WDATA;
                end
                default: e_d.st = ST_DROP;
            endcase
        end else if (tx_req_i) begin
            e_d.tx_v = 1'b1;
            e_d.tx_b = (e_q.st == ST_READ) ? sel_byte : FILL_BYTE;
            if (e_q.st == ST_READ && e_q.idx != '1) begin
                e_d.idx = e_q.idx + 1'b1;
            end
        end else if (mack_valid_i) begin
            if (e_q.st == ST_READ && !mack_i) begin
                e_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q      <= '0;
            e_q.st   <= ST_IDLE;
            e_q.pend <= SRC_NONE;
            e_q.src  <= SRC_NONE;
        end else begin
            e_q <= e_d;
        end
    end

    smbus_tx_sel #(
        .SEED_BYTES (SEED_BYTES),
        .CFG_REGS   (CFG_REGS),
        .IDX_W      (IDX_W)
    ) u_sel (
        .src_i  (e_q.src),
        .idx_i  (e_q.idx),
        .done_i (e_q.done),
        .seed_i (seed_o),
        .sec_i  (e_q.sec),
        .cfg_i  (e_q.cfg),
        .byte_o (sel_byte)
    );

    smbus_seed_store #(
        .SEED_BYTES (SEED_BYTES)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (seed_clr),
        .shift_i  (seed_shift),
        .byte_i   (rx_byte_i),
        .commit_i (seed_commit),
        .seed_o   (seed_o),
        .commit_o (commit_o)
    );

    assign ack_valid_o = e_q.ack_v;
    assign ack_o       = e_q.ack;
    assign tx_valid_o  = e_q.tx_v;
    assign tx_byte_o   = e_q.tx_b;

    // R11: each received byte gets an ACK/NACK decision one cycle later
    a_r11_ack_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !start_i && !stop_i) |=> ack_valid_o);

    // R11: each transmit request is answered one cycle later
    a_r11_tx_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req_i && !rx_valid_i && !start_i && !stop_i) |=> tx_valid_o);

    // R4: commit to the write stage only in the cycle after a STOP
    a_r4_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(stop_i));

    // R1: a foreign address is refused
    a_r1_foreign_addr_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_ADDR && rx_valid_i && !start_i && !stop_i
         && rx_byte_i[7:1] != DEV_ADDR) |=> (ack_valid_o && !ack_o));

    // R10: once the master has NACKed, only fill bytes go out
    a_r10_fill_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.done && tx_req_i && !rx_valid_i && !start_i && !stop_i)
        |=> (tx_byte_o == 8'hFF));

endmodule

// File: tb/sim_smbus_blk_engine.sv
module sim_smbus_blk_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, stop_i = 1'b0;
    logic        rx_valid_i = 1'b0;
    logic [7:0]  rx_byte_i = '0;
    logic        ack_valid_o, ack_o;
    logic        tx_req_i = 1'b0;
    logic        tx_valid_o;
    logic [7:0]  tx_byte_o;
    logic        mack_valid_i = 1'b0, mack_i = 1'b0;
    logic [23:0] cfg_i = 24'h5AC37E;
    logic [63:0] sec_code_i = '0;
    logic [63:0] seed_o;
    logic        commit_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    smbus_blk_engine u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
        .ack_valid_o(ack_valid_o), .ack_o(ack_o),
        .tx_req_i(tx_req_i), .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o),
        .mack_valid_i(mack_valid_i), .mack_i(mack_i),
        .cfg_i(cfg_i), .sec_code_i(sec_code_i),
        .seed_o(seed_o), .commit_o(commit_o)
    );

    // op codes: 0 START, 1 STOP (exp = commit), 2 write byte (exp = ack), 3 read (dat = master ack, exp = byte)
    localparam int NV = 35;
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 8'h00, 8'h00}, {2'd2, 8'h58, 8'h01}, {2'd2, 8'hC0, 8'h01}, {2'd2, 8'h08, 8'h01},
        {2'd2, 8'hA1, 8'h01}, {2'd2, 8'hB2, 8'h01}, {2'd2, 8'hC3, 8'h01}, {2'd2, 8'hD4, 8'h01},
        {2'd2, 8'hE5, 8'h01}, {2'd2, 8'hF6, 8'h01}, {2'd2, 8'h07, 8'h01}, {2'd2, 8'h18, 8'h01},
        {2'd1, 8'h00, 8'h01},
        {2'd0, 8'h00, 8'h00}, {2'd2, 8'h58, 8'h01}, {2'd2, 8'hC1, 8'h01}, {2'd0, 8'h00, 8'h00},
        {2'd2, 8'h59, 8'h01}, {2'd3, 8'h01, 8'h08}, {2'd3, 8'h01, 8'hA1}, {2'd3, 8'h01, 8'hB2},
        {2'd3, 8'h01, 8'hC3}, {2'd3, 8'h01, 8'hD4}, {2'd3, 8'h01, 8'hE5}, {2'd3, 8'h01, 8'hF6},
        {2'd3, 8'h01, 8'h07}, {2'd3, 8'h00, 8'h18}, {2'd1, 8'h00, 8'h00},
        {2'd0, 8'h00, 8'h00}, {2'd2, 8'h59, 8'h01}, {2'd3, 8'h01, 8'h03}, {2'd3, 8'h01, 8'h5A},
        {2'd3, 8'h01, 8'hC3}, {2'd3, 8'h00, 8'h7E}, {2'd1, 8'h00, 8'h00}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic do_stop(input bit exp_commit, input string req);
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk);
        chk(commit_o == exp_commit, req, 64'(commit_o), 64'(exp_commit));
        stop_i = 1'b0;
        @(negedge clk);
        chk(commit_o == 1'b0, "R4 single pulse", 64'(commit_o), 64'd0);
    endtask

    task automatic wr(input logic [7:0] b, input bit exp_ack, input string req);
        @(negedge clk) begin rx_valid_i = 1'b1; rx_byte_i = b; end
        @(negedge clk);
        chk(ack_valid_o == 1'b1, "R11 ack timing", 64'(ack_valid_o), 64'd1);
        chk(ack_o == exp_ack, req, 64'(ack_o), 64'(exp_ack));
        rx_valid_i = 1'b0;
    endtask

    task automatic rd(input bit m, input logic [7:0] exp, input string req);
        @(negedge clk) tx_req_i = 1'b1;
        @(negedge clk);
        chk(tx_valid_o == 1'b1, "R11 tx timing", 64'(tx_valid_o), 64'd1);
        chk(tx_byte_o == exp, req, 64'(tx_byte_o), 64'(exp));
        tx_req_i = 1'b0; mack_valid_i = 1'b1; mack_i = m;
        @(negedge clk) mack_valid_i = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(seed_o == 64'd0, "R4 reset seed", seed_o, 64'd0);
        chk(!ack_valid_o && !tx_valid_o && !commit_o, "R11 reset outputs",
            64'({ack_valid_o, tx_valid_o, commit_o}), 64'd0);

        // table: R3 seed write, R7 seed read back, R9 configuration read
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][17:16])
                2'd0: do_start();
                2'd1: do_stop(VEC[i][0], "R4 commit at STOP");
                2'd2: wr(VEC[i][15:8], VEC[i][0], "R3 R2 R1 ack");
                default: rd(VEC[i][8], VEC[i][7:0], "R7 R9 read byte");
            endcase
        end
        chk(seed_o == 64'hA1B2C3D4E5F60718, "R3 seed value", seed_o, 64'hA1B2C3D4E5F60718);

        // R8: captured at command, top bit forced
        sec_code_i = 64'h0123456789ABCDEF;
        do_start(); wr(8'h58, 1, "R8 addr"); wr(8'hC3, 1, "R8 cmd");
        sec_code_i = 64'h0000000000000000;
        do_start(); wr(8'h59, 1, "R8 addr rd");
        rd(1, 8'h08, "R8 count");
        rd(1, 8'h81, "R8 msb forced");
        rd(1, 8'h23, "R8 b2"); rd(1, 8'h45, "R8 b3"); rd(1, 8'h67, "R8 b4");
        rd(1, 8'h89, "R8 b5"); rd(1, 8'hAB, "R8 b6"); rd(1, 8'hCD, "R8 b7");
        rd(0, 8'hEF, "R8 b8");
        rd(1, 8'hFF, "R10 after last");
        do_stop(0, "R8 no commit");

        // R10: early master NACK
        do_start(); wr(8'h59, 1, "R10 addr");
        rd(1, 8'h03, "R10 count"); rd(0, 8'h5A, "R10 first");
        rd(1, 8'hFF, "R10 fill");
        do_stop(0, "R10 no commit");

        // R1: foreign address
        do_start(); wr(8'h60, 0, "R1 foreign nack"); wr(8'hC0, 0, "R1 rest ignored");
        do_stop(0, "R1 no commit");

        // R2: undefined command
        do_start(); wr(8'h58, 1, "R2 addr"); wr(8'hC2, 0, "R2 bad cmd nack");
        wr(8'h08, 0, "R2 dropped");
        do_stop(0, "R2 no commit");

        // R5: wrong byte count
        do_start(); wr(8'h58, 1, "R5 addr"); wr(8'hC0, 1, "R5 cmd");
        wr(8'h07, 0, "R5 count nack"); wr(8'h11, 0, "R5 dropped");
        do_stop(0, "R5 no commit");
        chk(seed_o == 64'hA1B2C3D4E5F60718, "R5 seed kept", seed_o, 64'hA1B2C3D4E5F60718);

        // R6: early STOP
        do_start(); wr(8'h58, 1, "R6 addr"); wr(8'hC0, 1, "R6 cmd"); wr(8'h08, 1, "R6 count");
        for (int k = 0; k < 5; k++) wr(8'(8'h11 * (k + 1)), 1, "R6 data");
        do_stop(0, "R6 abort no commit");
        chk(seed_o == 64'hA1B2C3D4E5F60718, "R6 seed kept", seed_o, 64'hA1B2C3D4E5F60718);

        // R4: seed holds until STOP
        do_start(); wr(8'h58, 1, "R4 addr"); wr(8'hC0, 1, "R4 cmd"); wr(8'h08, 1, "R4 count");
        for (int k = 0; k < 8; k++) wr(8'(8'h10 + k), 1, "R4 data");
        repeat (2) @(negedge clk);
        chk(seed_o == 64'hA1B2C3D4E5F60718, "R4 held before STOP", seed_o, 64'hA1B2C3D4E5F60718);
        do_stop(1, "R4 commit");
        chk(seed_o == 64'h1011121314151617, "R4 new seed", seed_o, 64'h1011121314151617);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule